// File: doc/BRIEF.md
# Configuration Image Header Parser

This block reads the leading bytes of a configuration image and works out two numbers: the byte offset at which the payload begins and how many payload bytes follow. Bytes arrive on a valid/ready stream, each with its own byte index, and are written into a local buffer of `2**BUF_AW` bytes. Once every buffer position has been accepted, the stream is held off and a control sequencer works through the buffered header.

The sequencer first reads the header length. From it, it finds the number of lookup records and walks those 9-byte records looking for the payload block and the component-size block. It then reads the component count and adds up the packed 22-bit component sizes, one component per cycle. The byte count is that sum scaled by 16.

The result is reported with a single-cycle done pulse. An error flag qualifies the pulse. After the pulse the parser is ready for the next image. Forwarding the payload itself is left to the surrounding logic.

Top module: `cfg_hdr_parser`

## Requirements
- R1: While filling, `in_ready` is 1 and each accepted byte is stored at buffer position `in_idx`, in whatever order the indices arrive. Parsing starts after `2**BUF_AW` bytes have been accepted, and `in_ready` stays 0 from then until the done pulse has been given.
- R2: The header length is the byte at offset 24. A header length of zero ends the parse with an error.
- R3: The record count is the byte at position (header length − 1). Records are 9 bytes each and begin at the header length. In each record, byte 0 is the block identifier and bytes 1..4 hold a 32-bit start offset, least significant byte first.
- R4: Identifier 8 gives the payload start and identifier 5 gives the start of the component-size list. When an identifier repeats, the later record replaces the earlier one. Scanning stops at the first record after which both identifiers have been seen, and any records after it are ignored.
- R5: If all records have been scanned, including the case of zero records, and either identifier has not been seen, the parse ends with an error.
- R6: A record whose bytes would reach position `2**BUF_AW` or beyond ends the parse with an error.
- R7: A payload start greater than `2**BUF_AW` is an error. A payload start equal to `2**BUF_AW` is accepted.
- R8: The component count is a 16-bit value at bytes 55 (low) and 56 (high). Component i is the 22-bit field that starts at bit 22·i of the size list, counting bits LSB first within each byte. `pay_len` equals the sum of all components times 16. With a count of zero, `pay_len` is 0.
- R9: A component whose last bit lies at buffer position `2**BUF_AW` or beyond ends the parse with an error.
- R10: If the 32-bit running byte count would overflow, the parse ends with an error.
- R11: `done` is a single-cycle pulse. `err`, `pay_start` and `pay_len` are updated only together with it and then hold their values. On an error, `pay_start` and `pay_len` are 0. The pulse appears L cycles after the edge that accepts the last buffer byte, where L depends on the outcome:
  - L = 2 for a zero header length.
  - L = 4 + r for a record overrun at record r.
  - L = 4 + n when an identifier is missing after n records.
  - L = 4 + k for a bad payload start, where k is the number of records scanned.
  - L = 5 + k + j for an error at component j.
  - L = 5 + k + c on success with c components.
- R12: In the cycle after `done`, `in_ready` is 1 again, and a new image is taken from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Parser is accepting bytes |
| in_data | input | 8 | Image byte |
| in_idx | input | BUF_AW | Byte position of `in_data` within the image |
| done | output | 1 | One-cycle pulse when a parse ends |
| err | output | 1 | Last parse failed; valid with `done` and held |
| pay_start | output | 32 | Payload start offset (0 on error) |
| pay_len | output | 32 | Payload byte count (0 on error) |

## Verification
Every result of this block falls due a fixed number of cycles after the edge that accepts the last buffer byte. That number is set by how many records were scanned before both identifiers were found, or before the failure, plus one cycle per component summed (R11). The bench's reference model works that latency out from the image bytes alone, together with the expected outcome. After the last byte, the bench compares `done`, `in_ready` and, on the due cycle, `err`, `pay_start` and `pay_len` at every falling edge. A pulse that comes early, comes late or lasts two cycles is therefore reported as a mismatch on the exact cycle.

// File: rtl/cfg_hdr_pkg.sv
// Shared constants and types for the configuration image header parser.
// Assumes images use the header layout described in doc/BRIEF.md.
package cfg_hdr_pkg;
    localparam int ADDR_W    = 34;  // wide enough that offset sums never wrap
    localparam int HLEN_POS  = 24;  // byte holding the header length
    localparam int CNT_POS   = 55;  // low byte of the component count
    localparam int REC_BYTES = 9;   // lookup record size
    localparam int ID_PAY    = 8;   // identifier of the payload block
    localparam int ID_SIZES  = 5;   // identifier of the component-size list
    localparam int FIELD_W   = 22;  // bits per packed component size
    localparam int SCALE_SH  = 4;   // component unit is 16 bytes
    localparam int NRD       = 5;   // buffer read ports

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_FILL, ST_HLEN, ST_NREC, ST_SCAN, ST_SINIT, ST_SIZE, ST_FIN
    } st_t;
endpackage

// File: rtl/cfg_hdr_store.sv
// Header byte buffer: one write port indexed by the stream byte index and
// NRD combinational read ports. Reads at or beyond the depth return zero.
// Assumes depth is a power of two so every index is in range.
module cfg_hdr_store
    import cfg_hdr_pkg::*;
#(
    parameter int BUF_AW = 8
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [BUF_AW-1:0]        wr_idx,
    input  logic [7:0]               wr_data,
    input  addr_t [NRD-1:0]          rd_addr,
    output logic [NRD-1:0][7:0]      rd_data
);
    localparam int    DEPTH   = 1 << BUF_AW;
    localparam addr_t DEPTH_A = addr_t'(DEPTH);

    logic [7:0] mem [DEPTH];

    // Store an accepted byte at its own index.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // One range-checked read mux per port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = (rd_addr[g] < DEPTH_A) ? mem[rd_addr[g][BUF_AW-1:0]] : 8'h00;
    end
endmodule

// File: rtl/cfg_hdr_field.sv
// Extracts one packed component size from a 32-bit little-endian window,
// given the bit offset of the field inside its first byte (0..7).
module cfg_hdr_field
    import cfg_hdr_pkg::*;
(
    input  logic [31:0]        word,
    input  logic [2:0]         off,
    output logic [FIELD_W-1:0] field
);
    // Shift the window down and keep the field width.
    assign field = FIELD_W'(word >> off);
endmodule

// File: rtl/cfg_hdr_ctrl.sv
// Control sequencer: counts the buffer fill, then walks header length,
// record count, lookup records, component count and component sizes, one
// step per cycle, and reports the outcome with a done pulse.
// Assumes the buffer read data settles within the cycle its address is driven.
module cfg_hdr_ctrl
    import cfg_hdr_pkg::*;
#(
    parameter int BUF_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    output addr_t [NRD-1:0]      rd_addr,
    input  logic [NRD-1:0][7:0]  rd_data,
    output logic [31:0]          fld_word,
    output logic [2:0]           fld_off,
    input  logic [FIELD_W-1:0]   fld_val,
    output logic                 done,
    output logic                 err,
    output logic [31:0]          pay_start,
    output logic [31:0]          pay_len
);
    localparam int    DEPTH   = 1 << BUF_AW;
    localparam addr_t DEPTH_A = addr_t'(DEPTH);
    localparam int    CNT_W   = BUF_AW + 1;

    st_t               state;
    logic [CNT_W-1:0]  fill_cnt;
    logic [7:0]        hlen;
    logic [7:0]        rec_left;
    addr_t             rec_ptr;
    logic              have_pay, have_lst;
    logic [31:0]       pay_reg, lst_reg;
    logic [15:0]       ncomp, cidx;
    logic [31:0]       bit_pos;
    logic [31:0]       acc;

    logic              last_byte, is_pay, is_lst, got_both, rec_over;
    logic [31:0]       rec_start;
    addr_t             fld_base, fld_last;
    logic [32:0]       sum;

    // Decode of the current step's buffer reads.
    always_comb begin
        last_byte = in_valid && in_ready && (fill_cnt == CNT_W'(DEPTH - 1));
        is_pay    = (rd_data[0] == 8'(ID_PAY));
        is_lst    = (rd_data[0] == 8'(ID_SIZES));
        got_both  = (have_pay || is_pay) && (have_lst || is_lst);
        rec_start = {rd_data[4], rd_data[3], rd_data[2], rd_data[1]};
        rec_over  = (rec_ptr + addr_t'(4)) >= DEPTH_A;
        fld_base  = addr_t'(lst_reg) + addr_t'(bit_pos >> 3);
        fld_last  = fld_base + addr_t'((5'(bit_pos[2:0]) + 5'(FIELD_W - 1)) >> 3);
        fld_word  = {rd_data[3], rd_data[2], rd_data[1], rd_data[0]};
        fld_off   = bit_pos[2:0];
        sum       = {1'b0, acc} + (33'(fld_val) << SCALE_SH);
        in_ready  = (state == ST_FILL);
        done      = (state == ST_FIN);
    end

    // Buffer read addresses for each step.
    always_comb begin
        for (int g = 0; g < NRD; g++) rd_addr[g] = '0;
        case (state)
            ST_HLEN:  rd_addr[0] = addr_t'(HLEN_POS);
            ST_NREC:  rd_addr[0] = addr_t'(hlen) - addr_t'(1);
            ST_SCAN:  for (int g = 0; g < NRD; g++) rd_addr[g] = rec_ptr + addr_t'(g);
            ST_SINIT: begin
                rd_addr[0] = addr_t'(CNT_POS);
                rd_addr[1] = addr_t'(CNT_POS + 1);
            end
            ST_SIZE:  for (int g = 0; g < 4; g++) rd_addr[g] = fld_base + addr_t'(g);
            default:  ;
        endcase
    end

    // Sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_FILL;
            fill_cnt  <= '0;
            hlen      <= '0;
            rec_left  <= '0;
            rec_ptr   <= '0;
            have_pay  <= 1'b0;
            have_lst  <= 1'b0;
            pay_reg   <= '0;
            lst_reg   <= '0;
            ncomp     <= '0;
            cidx      <= '0;
            bit_pos   <= '0;
            acc       <= '0;
            err       <= 1'b0;
            pay_start <= '0;
            pay_len   <= '0;
        end else begin
            case (state)
                ST_FILL: begin
                    if (in_valid) fill_cnt <= fill_cnt + CNT_W'(1);
                    if (last_byte) state <= ST_HLEN;
                end
                ST_HLEN: begin
                    hlen <= rd_data[0];
                    if (rd_data[0] == 8'd0) begin
                        err <= 1'b1; pay_start <= '0; pay_len <= '0; state <= ST_FIN;
                    end else begin
                        state <= ST_NREC;
                    end
                end
                ST_NREC: begin
                    rec_left <= rd_data[0];
                    rec_ptr  <= addr_t'(hlen);
                    have_pay <= 1'b0;
                    have_lst <= 1'b0;
                    state    <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (rec_left == 8'd0 || rec_over) begin
                        err <= 1'b1; pay_start <= '0; pay_len <= '0; state <= ST_FIN;
                    end else begin
                        if (is_pay) begin pay_reg <= rec_start; have_pay <= 1'b1; end
                        if (is_lst) begin lst_reg <= rec_start; have_lst <= 1'b1; end
                        rec_ptr  <= rec_ptr + addr_t'(REC_BYTES);
                        rec_left <= rec_left - 8'd1;
                        if (got_both) state <= ST_SINIT;
                    end
                end
                ST_SINIT: begin
                    if (addr_t'(pay_reg) > DEPTH_A) begin
                        err <= 1'b1; pay_start <= '0; pay_len <= '0; state <= ST_FIN;
                    end else begin
                        ncomp   <= {rd_data[1], rd_data[0]};
                        cidx    <= '0;
                        bit_pos <= '0;
                        acc     <= '0;
                        state   <= ST_SIZE;
                    end
                end
                ST_SIZE: begin
                    if (cidx == ncomp) begin
                        err <= 1'b0; pay_start <= pay_reg; pay_len <= acc; state <= ST_FIN;
                    end else if (fld_last >= DEPTH_A || sum[32]) begin
                        err <= 1'b1; pay_start <= '0; pay_len <= '0; state <= ST_FIN;
                    end else begin
                        acc     <= sum[31:0];
                        cidx    <= cidx + 16'd1;
                        bit_pos <= bit_pos + 32'(FIELD_W);
                    end
                end
                default: begin
                    fill_cnt <= '0;
                    state    <= ST_FILL;
                end
            endcase
        end
    end
endmodule

// File: rtl/cfg_hdr_parser.sv
// Top of the configuration image header parser: buffer, field extractor and
// sequencer. Assumes bytes of one image arrive with distinct indices.
module cfg_hdr_parser
    import cfg_hdr_pkg::*;
#(
    parameter int BUF_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic [BUF_AW-1:0] in_idx,
    output logic              done,
    output logic              err,
    output logic [31:0]       pay_start,
    output logic [31:0]       pay_len
);
    addr_t [NRD-1:0]      rd_addr;
    logic [NRD-1:0][7:0]  rd_data;
    logic [31:0]          fld_word;
    logic [2:0]           fld_off;
    logic [FIELD_W-1:0]   fld_val;
    logic                 wr_en;

    // Write only bytes the sequencer accepts.
    assign wr_en = in_valid && in_ready;

    cfg_hdr_store #(.BUF_AW(BUF_AW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(in_idx), .wr_data(in_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    cfg_hdr_field u_field (
        .word(fld_word), .off(fld_off), .field(fld_val)
    );

    cfg_hdr_ctrl #(.BUF_AW(BUF_AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .fld_word(fld_word), .fld_off(fld_off), .fld_val(fld_val),
        .done(done), .err(err), .pay_start(pay_start), .pay_len(pay_len)
    );
endmodule

// File: rtl/cfg_hdr_parser_chk.sv
// Port-level protocol checks for cfg_hdr_parser, attached by bind.
module cfg_hdr_parser_chk #(
    parameter int BUF_AW = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        done,
    input logic        err,
    input logic [31:0] pay_start,
    input logic [31:0] pay_len
);
    localparam int DEPTH = 1 << BUF_AW;

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r12_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready);
    a_r1_no_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);
    a_r12_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(done));
    a_r11_err_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (pay_start == 32'd0 && pay_len == 32'd0));
    a_r8_len_scaled: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (pay_len[3:0] == 4'd0));
    a_r7_start_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (pay_start <= 32'(DEPTH)));
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(err) && $stable(pay_start) && $stable(pay_len)));
endmodule

bind cfg_hdr_parser cfg_hdr_parser_chk #(.BUF_AW(BUF_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .done(done),
    .err(err), .pay_start(pay_start), .pay_len(pay_len)
);

// File: tb/sim_cfg_hdr_parser.sv
`timescale 1ns/1ps
module sim_cfg_hdr_parser;
    localparam int AW = 8;
    localparam int D  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic [AW-1:0] in_idx = '0;
    logic          in_ready, done, err;
    logic [31:0]   pay_start, pay_len;

    int checks = 0;
    int fails  = 0;
    logic [7:0] img [D];

    always #4 clk = ~clk;

    cfg_hdr_parser #(.BUF_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_idx(in_idx), .done(done), .err(err),
        .pay_start(pay_start), .pay_len(pay_len)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clr_img();
        for (int i = 0; i < D; i++) img[i] = 8'h00;
    endtask

    task automatic put_rec(input int at, input int id, input longint start);
        img[at] = 8'(id);
        for (int b = 0; b < 4; b++) img[at + 1 + b] = 8'(start >> (8 * b));
    endtask

    task automatic put_field(input int ls, input int i, input int val);
        for (int b = 0; b < 22; b++) begin
            int p = ls * 8 + i * 22 + b;
            img[p / 8][p % 8] = 1'((val >> b) & 1);
        end
    endtask

    task automatic set_count(input int n);
        img[55] = 8'(n);
        img[56] = 8'(n >> 8);
    endtask

    // Behavioural reference: outcome and latency from the image bytes.
    task automatic model(output bit e, output longint st, output longint ln, output int lat);
        int hl, nr, ptr, k, nc;
        bit fp, fl;
        longint ps, ls, acc;
        e = 1'b1; st = 0; ln = 0; fp = 0; fl = 0; ps = 0; ls = 0; k = 0;
        hl = img[24];
        if (hl == 0) begin lat = 2; return; end
        nr = (hl - 1 < D) ? int'(img[hl - 1]) : 0;
        ptr = hl;
        for (int r = 0; r < nr; r++) begin
            longint s;
            if (ptr + 4 >= D) begin lat = 4 + r; return; end
            s = 0;
            for (int b = 0; b < 4; b++) s |= longint'(img[ptr + 1 + b]) << (8 * b);
            if (img[ptr] == 8) begin ps = s; fp = 1; end
            if (img[ptr] == 5) begin ls = s; fl = 1; end
            ptr += 9;
            if (fp && fl) begin k = r + 1; break; end
        end
        if (!(fp && fl)) begin lat = 4 + nr; return; end
        if (ps > D) begin lat = 4 + k; return; end
        nc = int'(img[55]) | (int'(img[56]) << 8);
        acc = 0;
        for (int j = 0; j < nc; j++) begin
            longint fv, a;
            int off;
            a = ls + (j * 22) / 8;
            off = (j * 22) % 8;
            if (a + (off + 21) / 8 >= D) begin lat = 5 + k + j; return; end
            fv = 0;
            for (int b = 0; b < 22; b++) begin
                longint p = ls * 8 + j * 22 + b;
                fv |= longint'(img[p / 8][p % 8]) << b;
            end
            acc += fv * 16;
            if (acc > 64'hFFFF_FFFF) begin lat = 5 + k + j; return; end
        end
        e = 1'b0; st = ps; ln = acc; lat = 5 + k + nc;
    endtask

    // Stream the image, then compare the outputs on every cycle up to the result.
    task automatic run(input bit rev, input string req);
        bit e; longint st, ln; int lat;
        model(e, st, ln, lat);
        for (int n = 0; n < D; n++) begin
            int idx = rev ? D - 1 - n : n;
            @(negedge clk);
            if (n % 7 == 3) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            chk("R1", "in_ready while filling", in_ready, 1);
            chk("R11", "no done while filling", done, 0);
            in_valid = 1'b1;
            in_data  = img[idx];
            in_idx   = AW'(idx);
        end
        for (int t = 1; t <= lat + 2; t++) begin
            @(negedge clk);
            in_valid = 1'b0;
            chk(req, $sformatf("done at cycle %0d", t), done, (t == lat) ? 1 : 0);
            chk("R12", $sformatf("in_ready at cycle %0d", t), in_ready, (t > lat) ? 1 : 0);
            if (t == lat) begin
                chk(req, "err", err, e);
                chk(req, "pay_start", pay_start, st);
                chk(req, "pay_len", pay_len, ln);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset in_ready", in_ready, 1);
        chk("R11", "reset done", done, 0);
        chk("R11", "reset err", err, 0);
        chk("R11", "reset pay_len", pay_len, 0);
        rst_n = 1'b1;

        // R3 R8: basic table with an unrelated record first
        clr_img(); img[24] = 64; img[63] = 3;
        put_rec(64, 3, 7); put_rec(73, 5, 120); put_rec(82, 8, 200);
        set_count(4);
        put_field(120, 0, 1000); put_field(120, 1, 22'h3FFFFF);
        put_field(120, 2, 5); put_field(120, 3, 77777);
        run(1'b0, "R8");
        // R1: same image delivered in reverse index order
        run(1'b1, "R1");
        // R4: scan stops once both are found; the later record is ignored
        clr_img(); img[24] = 64; img[63] = 4;
        put_rec(64, 8, 150); put_rec(73, 5, 100); put_rec(82, 8, 9999);
        set_count(2); put_field(100, 0, 3); put_field(100, 1, 9);
        run(1'b0, "R4");
        // R4: repeated payload identifier before both found, the later wins
        clr_img(); img[24] = 64; img[63] = 3;
        put_rec(64, 8, 50); put_rec(73, 8, 180); put_rec(82, 5, 110);
        set_count(1); put_field(110, 0, 12345);
        run(1'b0, "R4");
        // R5: size-list identifier missing
        clr_img(); img[24] = 64; img[63] = 2;
        put_rec(64, 8, 90); put_rec(73, 2, 100);
        run(1'b0, "R5");
        // R5: zero records
        clr_img(); img[24] = 64; img[63] = 0;
        run(1'b0, "R5");
        // R2: zero header length
        clr_img(); img[24] = 0;
        run(1'b0, "R2");
        // R6: record runs past the buffer
        clr_img(); img[24] = 253; img[252] = 2;
        run(1'b0, "R6");
        // R7: payload start one past the buffer end
        clr_img(); img[24] = 64; img[63] = 2;
        put_rec(64, 5, 100); put_rec(73, 8, 257);
        run(1'b0, "R7");
        // R7 R8: payload start exactly at the buffer end, zero components
        clr_img(); img[24] = 64; img[63] = 2;
        put_rec(64, 5, 100); put_rec(73, 8, 256); set_count(0);
        run(1'b0, "R7");
        // R9: third component reaches past the buffer
        clr_img(); img[24] = 64; img[63] = 2;
        put_rec(64, 5, 250); put_rec(73, 8, 120); set_count(3);
        put_field(250, 0, 1); put_field(250, 1, 2);
        run(1'b0, "R9");
        // R10: running count overflows at the 65th full-size component
        clr_img(); img[24] = 30; img[29] = 2;
        put_rec(30, 5, 70); put_rec(39, 8, 256); set_count(70);
        for (int i = 70; i < D; i++) img[i] = 8'hFF;
        run(1'b0, "R10");
        // R12: a clean image right after an error parse
        clr_img(); img[24] = 64; img[63] = 2;
        put_rec(64, 5, 130); put_rec(73, 8, 140); set_count(2);
        put_field(130, 0, 22'h200000); put_field(130, 1, 1);
        run(1'b0, "R12");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule